// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a 32-bit processor core from the moment it decides to take a non-reset exception to the moment the first handler instruction address is in the program counter. It copies the status register before changing anything. It then raises supervisor privilege, turns tracing off and, for interrupts only, moves the interrupt mask up to the level being serviced. For an interrupt it obtains the vector number through an interrupt-acknowledge read. Any other exception brings its own vector number with the request.

Next it writes a three-word frame to the supervisor stack: the old program counter and the untouched status copy. It forms the table address as the vector base plus four times the vector number, reads the 32-bit handler address as two 16-bit reads, and loads it into the program counter. All memory traffic goes through one request/acknowledge port with 16-bit data. The sequencer holds each access until it is acknowledged. One request that arrives while a sequence is running is held and serviced afterwards.

Top module: `exc_entry_seq`

## Requirements
- R1: The status word written to the stack is the value `srIn` held when the sequence started, before any bit of it was altered.
- R2: Once a sequence starts, `srOut` has bit 13 (supervisor) set and bits 15:14 (trace) cleared.
- R3: For an interrupt, `srOut[10:8]` becomes the request level. For any other exception it keeps the value from `srIn[10:8]`.
- R4: An interrupt sequence begins with a read marked `busFc` = 4'hF at address {all ones above bit 3, level in bits 3:1, bit 0 set}, and takes the vector number from `busRdata[7:0]`. A non-interrupt sequence makes no such read and uses `excVector`.
- R5: Three writes with `busFc` = 4'h5 follow. The first puts `pcIn[15:0]` at SSP-2, the second puts `pcIn[31:16]` at SSP-4, and the third puts the saved status at SSP-6, where SSP is `sspIn`, all modulo 2^32. Afterwards `sspOut` equals SSP-6.
- R6: Two reads with `busFc` = 4'h5 follow, at A and A+2, where A = `vbrIn` + 4 × vector number (modulo 2^32).
- R7: `pcOut` becomes {word read at A, word read at A+2}. In the cycle it first shows that value, `done` is high for exactly one cycle.
- R8: While `busReq` is high and `busAck` is low, `busReq`, `busWe` and `busAddr` stay unchanged in the next cycle, so any number of wait states is tolerated.
- R9: A request raised while a sequence is busy is held. It runs in full after the current sequence has signalled `done`.
- R10: After reset, `busReq`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | One-cycle exception request |
| excIsIrq | input | 1 | Request is an interrupt |
| excLevel | input | 3 | Interrupt level of the request |
| excVector | input | VW | Vector number for non-interrupt exceptions |
| srIn | input | 16 | Current status register |
| pcIn | input | 32 | Current program counter |
| sspIn | input | AW | Current supervisor stack pointer |
| vbrIn | input | AW | Vector base register |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | Access is a write |
| busFc | output | 4 | Function code (4'hF acknowledge, 4'h5 supervisor data) |
| busAddr | output | AW | Byte address |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data, valid with `busAck` |
| busAck | input | 1 | Access complete |
| srOut | output | 16 | Modified status register |
| pcOut | output | 32 | Handler address once loaded |
| sspOut | output | AW | Stack pointer after the frame |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Program counter loaded, one-cycle pulse |

## Verification
The bench uses the default AW = 32 and VW = 8, so both the stack and the vector table can cross the top of the 32-bit space. Vector 255 against a base of 32'hFFFF_FC00 puts the handler words in the last four bytes of memory. A stack pointer of 4 makes the last frame word wrap to 32'hFFFF_FFFE. Runs without wait states and with up to three wait states check the ordering under back-to-back and stretched acknowledges. A second request issued mid-sequence checks the single held request.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int SR_T1_BIT   = 15;
  localparam int SR_T0_BIT   = 14;
  localparam int SR_S_BIT    = 13;
  localparam int SR_MASK_LO  = 8;
  localparam int SR_MASK_W   = 3;
  localparam logic [3:0] FC_ACK     = 4'hF;
  localparam logic [3:0] FC_SUPDATA = 4'h5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IACK, ST_PCL, ST_PCH, ST_SR, ST_VHI, ST_VLO, ST_FIN
  } seqState_t;

  typedef enum logic [2:0] {
    SEL_IACK, SEL_PCL, SEL_PCH, SEL_SR, SEL_VHI, SEL_VLO
  } busSel_t;

  typedef struct packed {
    logic    capture;
    logic    latchVec;
    logic    decSsp;
    logic    latchHi;
    logic    loadPc;
    busSel_t sel;
  } dpStrobe_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pendValid,
  input  logic      pendIrq,
  input  logic      busAck,
  output dpStrobe_t strb,
  output logic      busReq,
  output logic      busWe,
  output logic [3:0] busFc,
  output logic      busy,
  output logic      done
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (pendValid) stateNxt = pendIrq ? ST_IACK : ST_PCL;
      ST_IACK: if (busAck) stateNxt = ST_PCL;
      ST_PCL:  if (busAck) stateNxt = ST_PCH;
      ST_PCH:  if (busAck) stateNxt = ST_SR;
      ST_SR:   if (busAck) stateNxt = ST_VHI;
      ST_VHI:  if (busAck) stateNxt = ST_VLO;
      ST_VLO:  if (busAck) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  logic inBus, inPush;
  assign inBus  = (state != ST_IDLE) && (state != ST_FIN);
  assign inPush = (state == ST_PCL) || (state == ST_PCH) || (state == ST_SR);

  always_comb begin
    strb          = '0;
    strb.capture  = (state == ST_IDLE) && pendValid;
    strb.latchVec = (state == ST_IACK) && busAck;
    strb.decSsp   = inPush && busAck;
    strb.latchHi  = (state == ST_VHI) && busAck;
    strb.loadPc   = (state == ST_VLO) && busAck;
    unique case (state)
      ST_IACK: strb.sel = SEL_IACK;
      ST_PCL:  strb.sel = SEL_PCL;
      ST_PCH:  strb.sel = SEL_PCH;
      ST_SR:   strb.sel = SEL_SR;
      ST_VHI:  strb.sel = SEL_VHI;
      default: strb.sel = SEL_VLO;
    endcase
  end

  assign busReq = inBus;
  assign busWe  = inPush;
  assign busFc  = (state == ST_IACK) ? FC_ACK : FC_SUPDATA;
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_ACK_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busFc == FC_ACK) |-> !busWe); // R4

  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> !$rose(strb.capture) || $past(done)); // R9

endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic          excReq,
  input  logic          excIsIrq,
  input  logic [2:0]    excLevel,
  input  logic [VW-1:0] excVector,
  input  logic [DW-1:0] srIn,
  input  logic [2*DW-1:0] pcIn,
  input  logic [AW-1:0] sspIn,
  input  logic [AW-1:0] vbrIn,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          pendValid,
  output logic          pendIrq,
  output logic [DW-1:0] srOut,
  output logic [2*DW-1:0] pcOut,
  output logic [AW-1:0] sspOut
);

  localparam int PCW = 2 * DW;
  localparam logic [AW-1:0] WORD_BYTES = AW'(2);

  logic [2:0]    pendLevel, curLevel;
  logic [VW-1:0] pendVec, vecReg;
  logic [DW-1:0] savedSr, srReg, hiReg;
  logic [PCW-1:0] pcSave, pcReg;
  logic [AW-1:0] sspReg, vbrReg;

  // single held request; a new one always wins over consumption
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIrq   <= 1'b0;
      pendLevel <= '0;
      pendVec   <= '0;
    end else if (excReq) begin
      pendValid <= 1'b1;
      pendIrq   <= excIsIrq;
      pendLevel <= excLevel;
      pendVec   <= excVector;
    end else if (strb.capture) begin
      pendValid <= 1'b0;
    end
  end

  logic [DW-1:0] srMod;
  always_comb begin
    srMod = srIn;
    srMod[SR_T1_BIT] = 1'b0;
    srMod[SR_T0_BIT] = 1'b0;
    srMod[SR_S_BIT]  = 1'b1;
    if (pendIrq) srMod[SR_MASK_LO +: SR_MASK_W] = pendLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedSr  <= '0;
      srReg    <= '0;
      pcSave   <= '0;
      pcReg    <= '0;
      sspReg   <= '0;
      vbrReg   <= '0;
      vecReg   <= '0;
      curLevel <= '0;
      hiReg    <= '0;
    end else begin
      if (strb.capture) begin
        savedSr  <= srIn;
        srReg    <= srMod;
        pcSave   <= pcIn;
        sspReg   <= sspIn;
        vbrReg   <= vbrIn;
        vecReg   <= pendVec;
        curLevel <= pendLevel;
      end
      if (strb.latchVec) vecReg <= busRdata[VW-1:0];
      if (strb.decSsp)   sspReg <= sspReg - WORD_BYTES;
      if (strb.latchHi)  hiReg  <= busRdata;
      if (strb.loadPc)   pcReg  <= {hiReg, busRdata};
    end
  end

  logic [AW-1:0] pushAddr, tableAddr, ackAddr;
  assign pushAddr  = sspReg - WORD_BYTES;
  assign tableAddr = vbrReg + ({{(AW-VW){1'b0}}, vecReg} << 2);
  assign ackAddr   = {{(AW-4){1'b1}}, curLevel, 1'b1};

  always_comb begin
    busAddr  = tableAddr;
    busWdata = '0;
    unique case (strb.sel)
      SEL_IACK: busAddr = ackAddr;
      SEL_PCL:  begin busAddr = pushAddr; busWdata = pcSave[DW-1:0]; end
      SEL_PCH:  begin busAddr = pushAddr; busWdata = pcSave[PCW-1:DW]; end
      SEL_SR:   begin busAddr = pushAddr; busWdata = savedSr; end
      SEL_VHI:  busAddr = tableAddr;
      SEL_VLO:  busAddr = tableAddr + WORD_BYTES;
      default:  busAddr = tableAddr;
    endcase
  end

  assign srOut  = srReg;
  assign pcOut  = pcReg;
  assign sspOut = sspReg;

  AST_SUPER_ON: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> srOut[SR_S_BIT] && !srOut[SR_T1_BIT] && !srOut[SR_T0_BIT]); // R2

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !pendIrq) |=> srOut[SR_MASK_LO +: SR_MASK_W] == $past(srIn[SR_MASK_LO +: SR_MASK_W])); // R3

  AST_SSP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.decSsp |=> sspOut == $past(sspOut) - WORD_BYTES); // R5

  AST_SAVED_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_SR && strb.decSsp) |-> busWdata == savedSr); // R1

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          excReq,
  input  logic          excIsIrq,
  input  logic [2:0]    excLevel,
  input  logic [VW-1:0] excVector,
  input  logic [15:0]   srIn,
  input  logic [31:0]   pcIn,
  input  logic [AW-1:0] sspIn,
  input  logic [AW-1:0] vbrIn,
  output logic          busReq,
  output logic          busWe,
  output logic [3:0]    busFc,
  output logic [AW-1:0] busAddr,
  output logic [15:0]   busWdata,
  input  logic [15:0]   busRdata,
  input  logic          busAck,
  output logic [15:0]   srOut,
  output logic [31:0]   pcOut,
  output logic [AW-1:0] sspOut,
  output logic          busy,
  output logic          done
);

  dpStrobe_t strb;
  logic pendValid, pendIrq;

  exc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .pendIrq(pendIrq),
    .busAck(busAck), .strb(strb), .busReq(busReq), .busWe(busWe),
    .busFc(busFc), .busy(busy), .done(done)
  );

  exc_dpath #(.AW(AW), .VW(VW), .DW(16)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .excReq(excReq),
    .excIsIrq(excIsIrq), .excLevel(excLevel), .excVector(excVector),
    .srIn(srIn), .pcIn(pcIn), .sspIn(sspIn), .vbrIn(vbrIn),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .pendValid(pendValid), .pendIrq(pendIrq), .srOut(srOut),
    .pcOut(pcOut), .sspOut(sspOut)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq && $stable(busAddr) && $stable(busWe)); // R8

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, excReq, excIsIrq, busAck, busReq, busWe, busy, done;
  logic [2:0] excLevel;
  logic [7:0] excVector, ackVec;
  logic [15:0] srIn, srOut, busWdata, busRdata;
  logic [31:0] pcIn, pcOut, sspIn, vbrIn, busAddr, sspOut;
  logic [3:0] busFc;

  exc_entry_seq dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excIsIrq(excIsIrq),
    .excLevel(excLevel), .excVector(excVector), .srIn(srIn), .pcIn(pcIn),
    .sspIn(sspIn), .vbrIn(vbrIn), .busReq(busReq), .busWe(busWe),
    .busFc(busFc), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .srOut(srOut), .pcOut(pcOut),
    .sspOut(sspOut), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int latency = 0;
  int waitCnt = 0;

  function automatic logic [15:0] tableWord(input logic [31:0] a);
    return (a[15:0] ^ a[31:16]) + 16'h1357;
  endfunction

  // memory model
  always_comb busRdata = (busFc == 4'hF) ? {8'h00, ackVec} : tableWord(busAddr);

  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; waitCnt <= 0;
    end else if (busReq && !busAck) begin
      if (waitCnt >= latency) begin busAck <= 1'b1; waitCnt <= 0; end
      else waitCnt <= waitCnt + 1;
    end else busAck <= 1'b0;
  end

  typedef struct packed {
    logic        we;
    logic [3:0]  fc;
    logic [31:0] addr;
    logic [15:0] data;
  } busItem_t;

  busItem_t expQ[$];
  string    tagQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every completed access with the scoreboard
  logic prevWait = 1'b0;
  logic [31:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevWait) begin
        check(busReq && busAddr == prevAddr, "R8", "held address",
              busReq ? busAddr : 32'hDEAD_0000, prevAddr);
      end
      if (busReq && busAck) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected access", busAddr, 32'h0);
        end else begin
          busItem_t e;
          string t;
          bit ok;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          ok = (busWe == e.we) && (busFc == e.fc) && (busAddr == e.addr) &&
               (!e.we || busWdata == e.data);
          check(ok, t, "bus access addr", busAddr, e.addr);
          if (!ok) $display("  detail we %0b/%0b fc %h/%h data %h/%h",
                            busWe, e.we, busFc, e.fc, busWdata, e.data);
        end
      end
    end
    prevWait = rstN && busReq && !busAck;
    prevAddr = busAddr;
  end

  // driver: push the expected accesses for one sequence
  task automatic expectSeq(input bit irq, input logic [2:0] lvl,
                           input logic [7:0] vec, input logic [7:0] iv,
                           output logic [31:0] expPc, output logic [15:0] expSr);
    logic [7:0] v;
    logic [31:0] a;
    v = irq ? iv : vec;
    if (irq) begin
      expQ.push_back('{1'b0, 4'hF, {28'hFFFFFFF, lvl, 1'b1}, 16'h0}); tagQ.push_back("R4");
    end
    expQ.push_back('{1'b1, 4'h5, sspIn - 32'd2, pcIn[15:0]});  tagQ.push_back("R5");
    expQ.push_back('{1'b1, 4'h5, sspIn - 32'd4, pcIn[31:16]}); tagQ.push_back("R5");
    expQ.push_back('{1'b1, 4'h5, sspIn - 32'd6, srIn});        tagQ.push_back("R1");
    a = vbrIn + {22'h0, v, 2'b00};
    expQ.push_back('{1'b0, 4'h5, a, 16'h0});          tagQ.push_back("R6");
    expQ.push_back('{1'b0, 4'h5, a + 32'd2, 16'h0});  tagQ.push_back("R6");
    expPc = {tableWord(a), tableWord(a + 32'd2)};
    expSr = srIn;
    expSr[15:14] = 2'b00;
    expSr[13] = 1'b1;
    if (irq) expSr[10:8] = lvl;
  endtask

  task automatic fire(input bit irq, input logic [2:0] lvl, input logic [7:0] vec);
    @(negedge clk);
    excReq = 1'b1; excIsIrq = irq; excLevel = lvl; excVector = vec;
    @(negedge clk);
    excReq = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic finishSeq(input logic [31:0] expPc, input logic [15:0] expSr,
                           input logic [31:0] expSsp, input bit irq);
    bit seen;
    waitDone(seen);
    check(seen, "R7", "done seen", {31'h0, seen}, 32'h1);
    if (seen) begin
      check(pcOut == expPc, "R7", "pcOut", pcOut, expPc);
      check(srOut[15:13] == expSr[15:13], "R2", "srOut S/T", {16'h0, srOut}, {16'h0, expSr});
      check(srOut[10:8] == expSr[10:8], "R3", irq ? "mask raised" : "mask kept",
            {29'h0, srOut[10:8]}, {29'h0, expSr[10:8]});
      check(sspOut == expSsp, "R5", "sspOut", sspOut, expSsp);
      @(negedge clk);
      check(!done, "R7", "done one cycle", {31'h0, done}, 32'h0);
    end
  endtask

  task automatic runOne(input bit irq, input logic [2:0] lvl, input logic [7:0] vec);
    logic [31:0] p;
    logic [15:0] s;
    expectSeq(irq, lvl, vec, ackVec, p, s);
    fire(irq, lvl, vec);
    finishSeq(p, s, sspIn - 32'd6, irq);
    check(expQ.size() == 0, "R4", "accesses left", expQ.size(), 32'h0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; excReq = 1'b0; excIsIrq = 1'b0; excLevel = '0; excVector = '0;
    ackVec = 8'd0; srIn = '0; pcIn = '0; sspIn = '0; vbrIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busReq, "R10", "busReq", {31'h0, busReq}, 32'h0);
    check(!done,   "R10", "done",   {31'h0, done},   32'h0);
    check(!busy,   "R10", "busy",   {31'h0, busy},   32'h0);

    // plain exception, no wait states, trace on and mask 7 on entry
    latency = 0;
    srIn = 16'hC715; pcIn = 32'h0012_3456; sspIn = 32'h0000_8000; vbrIn = 32'h0;
    runOne(1'b0, 3'd2, 8'd5);

    // interrupt level 5, two wait states
    latency = 2; ackVec = 8'd64;
    srIn = 16'h8200; pcIn = 32'hABCD_0010; sspIn = 32'h0002_0000; vbrIn = 32'h0010_0000;
    runOne(1'b1, 3'd5, 8'd11);

    // top vector, table and stack both wrap the address space
    latency = 1;
    srIn = 16'h4300; pcIn = 32'h8000_0002; sspIn = 32'h0000_0004; vbrIn = 32'hFFFF_FC00;
    runOne(1'b0, 3'd0, 8'd255);

    // highest interrupt level, three wait states
    latency = 3; ackVec = 8'd200;
    srIn = 16'h0000; pcIn = 32'h0000_1000; sspIn = 32'h0000_4000; vbrIn = 32'h0000_0400;
    runOne(1'b1, 3'd7, 8'd0);

    // R9: second request raised while the first is running
    begin
      logic [31:0] p1, p2;
      logic [15:0] s1, s2;
      latency = 1; ackVec = 8'd70;
      srIn = 16'h2100; pcIn = 32'h0000_2222; sspIn = 32'h0000_9000; vbrIn = 32'h0000_0800;
      expectSeq(1'b0, 3'd0, 8'd9, ackVec, p1, s1);
      expectSeq(1'b1, 3'd3, 8'd0, ackVec, p2, s2);
      fire(1'b0, 3'd0, 8'd9);
      repeat (3) @(negedge clk);
      check(busy, "R9", "first running", {31'h0, busy}, 32'h1);
      fire(1'b1, 3'd3, 8'd0);
      finishSeq(p1, s1, sspIn - 32'd6, 1'b0);
      finishSeq(p2, s2, sspIn - 32'd6, 1'b1);
      check(expQ.size() == 0, "R9", "held request ran", expQ.size(), 32'h0);
    end

    repeat (5) @(negedge clk);
    check(!busy && !busReq, "R9", "idle at end", {30'h0, busy, busReq}, 32'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule